// File: doc/BRIEF.md
# Sweeping Pulse Tone Channel

This block produces one square-wave tone voice. A period divider, enabled by a divided clock strobe, walks through an eight-step waveform. Each duty setting marks some of those steps high. A high step emits the current envelope volume and a low step emits zero. Slow tick strobes drive a volume envelope, which steps once every few 64 Hz ticks, and a frequency sweep, which rewrites the period on a 128 Hz cadence. The sweep can also silence the channel when the period overflows.

Configuration arrives through separate write strobes, one each for the sweep, duty, envelope and period settings. A trigger strobe starts or restarts the voice. The channel is held in one of two states: `CH_OFF`, where the output is silent, and `CH_ON`, where it plays. Four transitions connect them. START (a trigger while the DAC is enabled) moves OFF to ON, or restarts ON. DAC_KILL (an envelope write of zero volume with downward direction) moves either state to OFF. SWEEP_OVF (the sweep adder result exceeding 0x7FF) moves ON to OFF. HOLD keeps the state in every other case. DAC_KILL has priority over START, and START has priority over SWEEP_OVF.

Top module: `sweep_pulse_channel`

## Requirements
- R1: After reset `active` is 0, `sample_out` is 0, and every configuration register is 0.
- R2: A trigger while the DAC is enabled sets `active` on the next clock edge. The DAC is enabled when the stored envelope initial volume is nonzero or its direction is up. The trigger also loads the period divider from the period register, sets the waveform step to 0, loads the envelope volume and timers, and reloads the sweep timer from the sweep pace.
- R3: While active, each `div_tick` raises the 11-bit divider by one. A `div_tick` that finds the divider at 2047 reloads it from the period register and advances the 3-bit waveform step, so each step lasts (2048 - period) ticks.
- R4: `sample_out` equals the envelope volume when active and the duty pattern is high at the current step, and 0 otherwise. The pattern is high for step >= 8 - H, where H is 1, 2, 4 or 6 for duty codes 0, 1, 2 or 3. A duty write takes effect at once.
- R5: A period write does not alter the step in progress. The new period is used from the next reload onward.
- R6: With a nonzero envelope pace latched at trigger, the volume changes by one every pace `env_tick`s. Direction 1 raises it and direction 0 lowers it. Pace 0 freezes it.
- R7: The envelope volume saturates at 15 going up and at 0 going down, and never wraps.
- R8: An envelope write with initial volume 0 and direction 0 clears `active` on the next edge. A trigger while the DAC is disabled leaves `active` at 0.
- R9: When the sweep timer expires on a `sweep_tick` with nonzero pace, the period register becomes P + (P >> shift) when direction is 0, or P - (P >> shift) when direction is 1.
- R10: In add direction, any `sweep_tick` while active whose sum P + (P >> shift) exceeds 0x7FF clears `active` and leaves the period unchanged. This applies even when the pace is 0.
- R11: A sweep pace of 0 stops iterations from the next `sweep_tick`. When the pace becomes nonzero again, the next `sweep_tick` reloads the timer. A nonzero pace written mid-count is used only when the current count completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_tick | input | 1 | Period divider enable strobe |
| sweep_tick | input | 1 | 128 Hz sweep tick strobe |
| env_tick | input | 1 | 64 Hz envelope tick strobe |
| wr_sweep | input | 1 | Sweep configuration write |
| sweep_pace_in | input | 3 | Sweep pace (0 disables) |
| sweep_sub_in | input | 1 | Sweep direction, 1 = subtract |
| sweep_shift_in | input | 3 | Sweep shift amount |
| wr_duty | input | 1 | Duty write |
| duty_in | input | 2 | Duty code |
| wr_env | input | 1 | Envelope configuration write |
| env_init_in | input | 4 | Envelope initial volume |
| env_up_in | input | 1 | Envelope direction, 1 = up |
| env_pace_in | input | 3 | Envelope pace (0 disables) |
| wr_period | input | 1 | Period write |
| period_in | input | 11 | Period value |
| trigger | input | 1 | Start or restart strobe |
| sample_out | output | 4 | Digital sample |
| active | output | 1 | Channel playing flag |

## Verification
The bench targets the overflow kill while the sweep pace is 0. A design that gates the check with the pace would keep playing at a period it can never reach. It drives the envelope into both rails, where a wrapping counter would jump from loud to silent. It writes the period mid-step, where a design that reloads at once would shorten the step being played. It also lowers the sweep pace to 0 and raises it again: a design that keeps the stale count would rewrite the period too early, or never.

// File: rtl/pulse_pkg.sv
package pulse_pkg;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_ON  = 1'b1
    } ch_state_e;

    // High portion of the eight-step waveform for each duty code
    function automatic logic duty_high(input logic [1:0] duty, input logic [2:0] step);
        logic hi;
        unique case (duty)
            2'd0:    hi = (step == 3'd7);
            2'd1:    hi = (step >= 3'd6);
            2'd2:    hi = (step >= 3'd4);
            default: hi = (step >= 3'd2);
        endcase
        return hi;
    endfunction

endpackage

// File: rtl/pulse_divider.sv
module pulse_divider #(
    parameter int PER_W  = 11,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic              tick,
    input  logic [PER_W-1:0]  period,
    output logic [STEP_W-1:0] step
);
    localparam logic [PER_W-1:0] CNT_TOP = '1;

    logic [PER_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            step  <= '0;
        end else if (start) begin
            cnt_q <= period;
            step  <= '0;
        end else if (run && tick) begin
            if (cnt_q == CNT_TOP) begin
                cnt_q <= period;
                step  <= step + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: the waveform step only moves on a divider strobe or a restart
    p_step_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !tick) |=> $stable(step));

endmodule

// File: rtl/pulse_envelope.sv
module pulse_envelope #(
    parameter int VOL_W  = 4,
    parameter int PACE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic              tick,
    input  logic [VOL_W-1:0]  init_vol,
    input  logic              dir_up,
    input  logic [PACE_W-1:0] pace,
    output logic [VOL_W-1:0]  vol
);
    localparam logic [VOL_W-1:0]  VOL_MAX = '1;
    localparam logic [PACE_W-1:0] ONE     = PACE_W'(1);

    logic              dir_l;
    logic [PACE_W-1:0] pace_l;
    logic [PACE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol    <= '0;
            dir_l  <= 1'b0;
            pace_l <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            vol    <= init_vol;
            dir_l  <= dir_up;
            pace_l <= pace;
            cnt_q  <= pace;
        end else if (run && tick && (pace_l != '0)) begin
            if (cnt_q <= ONE) begin
                cnt_q <= pace_l;
                if (dir_l && (vol != VOL_MAX))
                    vol <= vol + 1'b1;
                else if (!dir_l && (vol != '0))
                    vol <= vol - 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R6: without a restart the volume moves by at most one level per cycle
    p_vol_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (vol == $past(vol) || vol == $past(vol) + 1'b1 || vol == $past(vol) - 1'b1));

    // R7: no wrap from the top rail to silence
    p_vol_no_wrap_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && vol == VOL_MAX) |=> (vol != '0));

    // R7: no wrap from silence to the top rail
    p_vol_no_wrap_bot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && vol == '0) |=> (vol != VOL_MAX));

endmodule

// File: rtl/pulse_sweep.sv
module pulse_sweep #(
    parameter int PER_W   = 11,
    parameter int PACE_W  = 3,
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               run,
    input  logic               tick,
    input  logic [PACE_W-1:0]  pace,
    input  logic               dir_sub,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [PER_W-1:0]   period,
    output logic               wb_valid,
    output logic [PER_W-1:0]   wb_period,
    output logic               overflow
);
    localparam logic [PACE_W-1:0] ONE = PACE_W'(1);

    logic [PER_W-1:0]  delta;
    logic [PER_W:0]    sum;
    logic [PER_W-1:0]  diff;
    logic              live_tick;
    logic              due;
    logic              en_q;
    logic [PACE_W-1:0] cnt_q;

    always_comb begin
        delta     = period >> shift;
        sum       = {1'b0, period} + {1'b0, delta};
        diff      = period - delta;
        live_tick = run && tick && !start;
        overflow  = live_tick && !dir_sub && sum[PER_W];
        due       = live_tick && (pace != '0) && en_q && (cnt_q <= ONE);
        wb_valid  = due && !overflow;
        wb_period = dir_sub ? diff : sum[PER_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            en_q  <= (pace != '0);
            cnt_q <= pace;
        end else if (run && tick) begin
            if (pace == '0) begin
                en_q <= 1'b0;
            end else if (!en_q) begin
                en_q  <= 1'b1;
                cnt_q <= pace;
            end else if (cnt_q <= ONE) begin
                cnt_q <= pace;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R11: a tick seen with pace 0 blocks any write-back in the following cycle
    p_pace0_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !start && pace == '0) |=> !wb_valid);

endmodule

// File: rtl/sweep_pulse_channel.sv
module sweep_pulse_channel
    import pulse_pkg::*;
#(
    parameter int PER_W   = 11,
    parameter int VOL_W   = 4,
    parameter int PACE_W  = 3,
    parameter int SHIFT_W = 3,
    parameter int DUTY_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               div_tick,
    input  logic               sweep_tick,
    input  logic               env_tick,
    input  logic               wr_sweep,
    input  logic [PACE_W-1:0]  sweep_pace_in,
    input  logic               sweep_sub_in,
    input  logic [SHIFT_W-1:0] sweep_shift_in,
    input  logic               wr_duty,
    input  logic [DUTY_W-1:0]  duty_in,
    input  logic               wr_env,
    input  logic [VOL_W-1:0]   env_init_in,
    input  logic               env_up_in,
    input  logic [PACE_W-1:0]  env_pace_in,
    input  logic               wr_period,
    input  logic [PER_W-1:0]   period_in,
    input  logic               trigger,
    output logic [VOL_W-1:0]   sample_out,
    output logic               active
);
    localparam int STEP_W = 3;

    ch_state_e          state_q, state_d;
    logic [PER_W-1:0]   period_q;
    logic [DUTY_W-1:0]  duty_q;
    logic [VOL_W-1:0]   env_init_q;
    logic               env_up_q;
    logic [PACE_W-1:0]  env_pace_q;
    logic [PACE_W-1:0]  sw_pace_q;
    logic               sw_sub_q;
    logic [SHIFT_W-1:0] sw_shift_q;

    logic               dac_on;
    logic               dac_kill;
    logic               start;
    logic               run;
    logic [STEP_W-1:0]  step;
    logic [VOL_W-1:0]   vol;
    logic               sw_wb;
    logic [PER_W-1:0]   sw_period;
    logic               sw_ovf;

    assign dac_on   = (env_init_q != '0) || env_up_q;
    assign dac_kill = wr_env && (env_init_in == '0) && !env_up_in;
    assign start    = trigger && dac_on;
    assign run      = (state_q == CH_ON);

    // Configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q   <= '0;
            duty_q     <= '0;
            env_init_q <= '0;
            env_up_q   <= 1'b0;
            env_pace_q <= '0;
            sw_pace_q  <= '0;
            sw_sub_q   <= 1'b0;
            sw_shift_q <= '0;
        end else begin
            if (wr_period)
                period_q <= period_in;
            else if (sw_wb)
                period_q <= sw_period;
            if (wr_duty)
                duty_q <= duty_in;
            if (wr_env) begin
                env_init_q <= env_init_in;
                env_up_q   <= env_up_in;
                env_pace_q <= env_pace_in;
            end
            if (wr_sweep) begin
                sw_pace_q  <= sweep_pace_in;
                sw_sub_q   <= sweep_sub_in;
                sw_shift_q <= sweep_shift_in;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (dac_kill)     state_d = CH_OFF;
                else if (start)   state_d = CH_ON;
            end
            CH_ON: begin
                if (dac_kill)     state_d = CH_OFF;
                else if (start)   state_d = CH_ON;
                else if (sw_ovf)  state_d = CH_OFF;
            end
            default:              state_d = CH_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        active     = run;
        sample_out = (run && duty_high(duty_q, step)) ? vol : '0;
    end

    pulse_divider #(.PER_W(PER_W), .STEP_W(STEP_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .run    (run),
        .tick   (div_tick),
        .period (period_q),
        .step   (step)
    );

    pulse_envelope #(.VOL_W(VOL_W), .PACE_W(PACE_W)) u_env (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .run      (run),
        .tick     (env_tick),
        .init_vol (env_init_q),
        .dir_up   (env_up_q),
        .pace     (env_pace_q),
        .vol      (vol)
    );

    pulse_sweep #(.PER_W(PER_W), .PACE_W(PACE_W), .SHIFT_W(SHIFT_W)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .run       (run),
        .tick      (sweep_tick),
        .pace      (sw_pace_q),
        .dir_sub   (sw_sub_q),
        .shift     (sw_shift_q),
        .period    (period_q),
        .wb_valid  (sw_wb),
        .wb_period (sw_period),
        .overflow  (sw_ovf)
    );

    // R2: an accepted trigger always starts the channel
    p_trig_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && dac_on && !dac_kill) |=> active);

    // R8: disabling the DAC silences the channel
    p_dac_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dac_kill |=> !active);

    // R8: a trigger with the DAC disabled cannot start an idle channel
    p_trig_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && !dac_on && !active) |=> !active);

    // R10: a sweep overflow stops the channel
    p_ovf_kill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ovf |=> !active);

endmodule

// File: tb/tb_sweep_pulse_channel.sv
module tb_sweep_pulse_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_tick = 1'b1;
    logic        sweep_tick = 1'b0;
    logic        env_tick = 1'b0;
    logic        wr_sweep = 1'b0;
    logic [2:0]  sweep_pace_in = '0;
    logic        sweep_sub_in = 1'b0;
    logic [2:0]  sweep_shift_in = '0;
    logic        wr_duty = 1'b0;
    logic [1:0]  duty_in = '0;
    logic        wr_env = 1'b0;
    logic [3:0]  env_init_in = '0;
    logic        env_up_in = 1'b0;
    logic [2:0]  env_pace_in = '0;
    logic        wr_period = 1'b0;
    logic [10:0] period_in = '0;
    logic        trigger = 1'b0;
    logic [3:0]  sample_out;
    logic        active;

    sweep_pulse_channel dut (
        .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .sweep_tick(sweep_tick),
        .env_tick(env_tick), .wr_sweep(wr_sweep), .sweep_pace_in(sweep_pace_in),
        .sweep_sub_in(sweep_sub_in), .sweep_shift_in(sweep_shift_in),
        .wr_duty(wr_duty), .duty_in(duty_in), .wr_env(wr_env),
        .env_init_in(env_init_in), .env_up_in(env_up_in), .env_pace_in(env_pace_in),
        .wr_period(wr_period), .period_in(period_in), .trigger(trigger),
        .sample_out(sample_out), .active(active)
    );

    always #2 clk = ~clk;

    integer checks = 0;
    integer errors = 0;
    string  cur_req = "R1";
    integer cyc = 0;
    integer env_iv = 0;
    integer sw_iv = 0;
    bit     done = 0;

    // Behavioural reference state
    integer m_on, m_cnt, m_step, m_vol, m_ecnt, m_edir, m_epace;
    integer m_scnt, m_sen, m_per;
    integer c_duty, c_init, c_edir, c_epace, c_space, c_sdir, c_shift;

    function automatic integer high_steps(input integer d);
        case (d)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 6;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = 0; m_cnt = 0; m_step = 0; m_vol = 0; m_ecnt = 0; m_edir = 0;
            m_epace = 0; m_scnt = 0; m_sen = 0; m_per = 0;
            c_duty = 0; c_init = 0; c_edir = 0; c_epace = 0;
            c_space = 0; c_sdir = 0; c_shift = 0;
        end else begin
            integer go, kill, delta, total, ovf, due, nper, non;
            go    = (trigger && (c_init != 0 || c_edir != 0)) ? 1 : 0;
            kill  = (wr_env && env_init_in == 0 && !env_up_in) ? 1 : 0;
            delta = m_per >> c_shift;
            total = c_sdir ? (m_per - delta) : (m_per + delta);
            ovf   = (m_on && sweep_tick && !go && !c_sdir && (m_per + delta > 2047)) ? 1 : 0;
            due   = (m_on && sweep_tick && !go && c_space != 0 && m_sen && m_scnt <= 1) ? 1 : 0;
            nper  = m_per;
            if (wr_period) nper = period_in;
            else if (due && !ovf) nper = total;
            non = kill ? 0 : (go ? 1 : (ovf ? 0 : m_on));
            // divider
            if (go) begin
                m_cnt = m_per; m_step = 0;
            end else if (m_on && div_tick) begin
                if (m_cnt == 2047) begin m_cnt = m_per; m_step = (m_step + 1) % 8; end
                else m_cnt = m_cnt + 1;
            end
            // envelope
            if (go) begin
                m_vol = c_init; m_edir = c_edir; m_epace = c_epace; m_ecnt = c_epace;
            end else if (m_on && env_tick && m_epace != 0) begin
                if (m_ecnt <= 1) begin
                    m_ecnt = m_epace;
                    if (m_edir && m_vol < 15) m_vol = m_vol + 1;
                    else if (!m_edir && m_vol > 0) m_vol = m_vol - 1;
                end else m_ecnt = m_ecnt - 1;
            end
            // sweep timer
            if (go) begin
                m_scnt = c_space; m_sen = (c_space != 0);
            end else if (m_on && sweep_tick) begin
                if (c_space == 0) m_sen = 0;
                else if (!m_sen) begin m_sen = 1; m_scnt = c_space; end
                else if (m_scnt <= 1) m_scnt = c_space;
                else m_scnt = m_scnt - 1;
            end
            m_per = nper;
            m_on  = non;
            if (wr_duty) c_duty = duty_in;
            if (wr_env) begin c_init = env_init_in; c_edir = env_up_in; c_epace = env_pace_in; end
            if (wr_sweep) begin c_space = sweep_pace_in; c_sdir = sweep_sub_in; c_shift = sweep_shift_in; end
        end
    end

    // Compare away from the edge, then produce the periodic strobes
    always @(negedge clk) begin
        integer exp_s;
        exp_s = (m_on && (m_step >= 8 - high_steps(c_duty))) ? m_vol : 0;
        checks = checks + 1;
        if (sample_out !== 4'(exp_s) || active !== 1'(m_on)) begin
            errors = errors + 1;
            $display("FAIL %s cycle %0d: sample %0d active %0d, expected sample %0d active %0d",
                     cur_req, cyc, sample_out, active, exp_s, m_on);
        end
        cyc = cyc + 1;
        env_tick   = (env_iv != 0) && (cyc % env_iv == 0);
        sweep_tick = (sw_iv != 0) && (cyc % sw_iv == 0);
    end

    task automatic idle(input integer n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_period(input integer v);
        @(negedge clk); wr_period = 1'b1; period_in = 11'(v);
        @(negedge clk); wr_period = 1'b0;
    endtask

    task automatic put_duty(input integer d);
        @(negedge clk); wr_duty = 1'b1; duty_in = 2'(d);
        @(negedge clk); wr_duty = 1'b0;
    endtask

    task automatic put_env(input integer iv, input integer up, input integer pc);
        @(negedge clk); wr_env = 1'b1; env_init_in = 4'(iv); env_up_in = 1'(up); env_pace_in = 3'(pc);
        @(negedge clk); wr_env = 1'b0;
    endtask

    task automatic put_sweep(input integer pc, input integer sub, input integer sh);
        @(negedge clk); wr_sweep = 1'b1; sweep_pace_in = 3'(pc); sweep_sub_in = 1'(sub); sweep_shift_in = 3'(sh);
        @(negedge clk); wr_sweep = 1'b0;
    endtask

    task automatic fire;
        @(negedge clk); trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
    endtask

    initial begin
        integer seed;
        // R1: reset state
        cur_req = "R1 reset";
        idle(5);
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        // R2 R3 R4: trigger, step timing, all duty codes
        cur_req = "R2/R3/R4 duty";
        put_env(15, 0, 0);
        put_period(2044);
        fire();
        for (int d = 0; d < 4; d++) begin
            put_duty(d);
            idle(40);
        end

        // R5: period write mid-step
        cur_req = "R5 period";
        idle(2);
        put_period(2040);
        idle(40);
        put_period(2046);
        idle(20);

        // R6 R7: envelope up to the top rail, then down to zero
        cur_req = "R6/R7 envelope";
        env_iv = 5;
        put_duty(2);
        put_env(3, 1, 1);
        fire();
        idle(100);
        put_env(2, 0, 2);
        fire();
        idle(60);

        // R8: DAC off kills, trigger ignored
        cur_req = "R8 dac";
        put_env(0, 0, 0);
        idle(4);
        fire();
        idle(10);
        env_iv = 0;
        put_env(9, 0, 0);
        fire();
        idle(5);

        // R9 R10: add sweep climbs then overflows
        cur_req = "R9/R10 sweep add";
        put_period(256);
        put_sweep(1, 0, 1);
        sw_iv = 7;
        fire();
        idle(60);

        // R9: subtract sweep
        cur_req = "R9 sweep sub";
        put_period(1024);
        put_sweep(2, 1, 2);
        fire();
        idle(80);

        // R10: overflow check with pace 0
        cur_req = "R10 pace0 ovf";
        put_period(1280);
        put_sweep(0, 0, 0);
        fire();
        idle(20);

        // R11: pace 0 stops iterations; nonzero pace reloads
        cur_req = "R11 pace";
        put_period(256);
        put_sweep(3, 0, 3);
        fire();
        idle(10);
        put_sweep(0, 0, 3);
        idle(30);
        put_sweep(1, 0, 3);
        idle(40);
        put_sweep(4, 0, 3);
        idle(40);

        // Mixed traffic across all requirements (R2-R11)
        cur_req = "R2-mix";
        cur_req = "mixed R4 R6 R9 R10";
        seed = 32'h1ACE;
        env_iv = 3;
        sw_iv = 11;
        for (int i = 0; i < 400; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
            case ((seed >> 8) % 8)
                0: put_period(1900 + ((seed >> 12) % 148));
                1: put_duty((seed >> 12) % 4);
                2: put_env((seed >> 12) % 16, (seed >> 17) % 2, (seed >> 18) % 8);
                3: put_sweep((seed >> 12) % 8, (seed >> 15) % 2, (seed >> 16) % 8);
                4, 5: fire();
                default: idle((seed >> 12) % 16);
            endcase
        end
        idle(20);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule